// File: doc/BRIEF.md
# SIMD Shift and Boolean Logic Unit

This unit executes the shift class and the bitwise class of a small vector processor. Operands are 64-bit registers. Shifts treat the register either as eight 8-bit lanes or as four 16-bit lanes. Lane i occupies bits `[w*i + w-1 : w*i]`. Each lane can be shifted left, shifted right logically or arithmetically, or rotated in either direction. The shift amount comes from one of two places: the low bits of the matching source lane, or the 4-bit source field of the instruction. The bitwise class treats a 4-bit code as a truth table over each bit pair taken from source and destination. One code value swaps the two registers instead, and one value does nothing.

The issue stage presents an operation with `opValid`, together with the opcode, the extra field, the source field and both register values. One clock edge later the unit presents the new destination value and the new source value. It also presents a write enable for each register, which tells the register file what to commit.

Top module: `simd_shlogic_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `resValid`, `dstWe` and `srcWe` are 0 and `dstNew` and `srcNew` are zero. A reset asserted in the middle of a run clears them in the same way.
- R2: An operation presented with `opValid` high is reported on `resValid`, `dstWe`, `srcWe`, `dstNew` and `srcNew` after exactly one rising edge. Operations may arrive on consecutive cycles. In a cycle that follows one with `opValid` low, `resValid`, `dstWe` and `srcWe` are 0.
- R3: Opcode 0xA shifts in eight 8-bit lanes and opcode 0xB shifts in four 16-bit lanes. Each lane is processed independently and nothing crosses a lane boundary.
- R4: Bits `extraField[1:0]` select the shift kind. 00 is a left shift with zero fill. 01 is a right shift with zero fill. 10 is a right shift that copies the sign bit. 11 is a left rotate. The code `extraField[2:0]` = 111 therefore acts as a right rotate.
- R5: With `extraField[3]` = 0, each lane's amount is the low 3 bits (8-bit lanes) or the low 4 bits (16-bit lanes) of the same lane of `srcVal`. All other source bits and `srcField` are ignored.
- R6: With `extraField[3]` = 1, the amount for every lane is `srcField`, reduced modulo the lane width. For 8-bit lanes only `srcField[2:0]` is used.
- R7: With `extraField[2]` = 1, the amount a is replaced by (lane width − a) mod lane width before the kind in R4 is applied. An amount of 0 leaves the lane unchanged.
- R8: Opcode 0xC computes each result bit as `extraField[2*d + s]`, where d and s are that bit of `dstVal` and `srcVal`. This yields 0x0 zero, 0xF ones, 0x8 AND, 0xE OR, 0x6 XOR, 0x7 NAND, 0x1 NOR, 0x9 XNOR, 0x5 NOT s, 0x3 NOT d, 0x2 s AND NOT d, 0x4 NOT s AND d, 0xB s OR NOT d and 0xD NOT s OR d.
- R9: Opcode 0xC with code 0xA swaps the registers. `dstNew` is the old `srcVal`, `srcNew` is the old `dstVal`, and both `dstWe` and `srcWe` are 1.
- R10: Opcode 0xC with code 0xC is a no-op. Both write enables are 0 and `dstNew` equals `dstVal`.
- R11: Code 0x6 applied with equal source and destination values gives a zero destination.
- R12: Shift operations and non-swap bitwise operations set `dstWe` to 1, set `srcWe` to 0, and return `srcNew` equal to `srcVal`. Any other opcode sets neither write enable and returns both values unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| opValid | input | 1 | Operation present this cycle |
| opcode | input | 4 | Instruction class (0xA, 0xB, 0xC handled) |
| extraField | input | 4 | Shift select or truth-table code |
| srcField | input | 4 | Instruction source field, used as an immediate amount |
| srcVal | input | 64 | Source register value |
| dstVal | input | 64 | Destination register value |
| resValid | output | 1 | Result of the previous cycle's operation |
| dstWe | output | 1 | Commit `dstNew` to the destination register |
| dstNew | output | 64 | New destination value |
| srcWe | output | 1 | Commit `srcNew` to the source register |
| srcNew | output | 64 | New source value (differs only on swap) |

## Verification
The two writes that can fall in the same cycle are the destination write and the source write of a swap. The bench provokes them with distinct, non-overlapping operands, so that a crossed or duplicated value shows up. It checks both write enables and both values in the result cycle. It then issues a plain operation on the very next cycle and checks that the source write drops and that `srcNew` returns to the passed-through source. A second overlap is a new operation accepted in the cycle a previous result is presented. Back-to-back issue, judged value by value, covers it.

// File: rtl/shlu_pkg.sv
package shlu_pkg;

  localparam int VecW    = 64;
  localparam int NarrowW = 8;
  localparam int WideW   = 16;
  localparam int FieldW  = 4;

  localparam logic [3:0] OpShiftNarrow = 4'hA;
  localparam logic [3:0] OpShiftWide   = 4'hB;
  localparam logic [3:0] OpBitLogic    = 4'hC;

  localparam logic [3:0] CodeSwap = 4'hA;
  localparam logic [3:0] CodeNop  = 4'hC;

  typedef enum logic [1:0] {
    ShLeft     = 2'b00,
    ShRightLog = 2'b01,
    ShRightAri = 2'b10,
    ShRotLeft  = 2'b11
  } shKind_e;

  typedef struct packed {
    logic    capture;
    logic    doShift;
    logic    narrow;
    logic    useField;
    logic    negAmt;
    shKind_e kind;
    logic    doLogic;
    logic    doSwap;
    logic    wrDst;
    logic    wrSrc;
  } ctrlStrobes_t;

endpackage

// File: rtl/shlu_lane.sv
module shlu_lane
  import shlu_pkg::*;
#(
  parameter int W  = 8,
  localparam int AW = $clog2(W)
) (
  input  logic [W-1:0]  laneIn,
  input  logic [AW-1:0] amt,
  input  shKind_e       kind,
  output logic [W-1:0]  laneOut
);

  logic signed [W-1:0] signedIn;
  logic [2*W-1:0]      doubled;

  assign signedIn = laneIn;
  assign doubled  = {laneIn, laneIn} << amt;

  always_comb begin
    unique case (kind)
      ShLeft:     laneOut = laneIn << amt;
      ShRightLog: laneOut = laneIn >> amt;
      ShRightAri: laneOut = signedIn >>> amt;
      default:    laneOut = doubled[2*W-1:W];
    endcase
  end

endmodule

// File: rtl/shlu_lanes.sv
module shlu_lanes
  import shlu_pkg::*;
#(
  parameter int VW = 64,
  parameter int W  = 8,
  localparam int NL = VW / W,
  localparam int AW = $clog2(W)
) (
  input  logic [VW-1:0]    laneData,
  input  logic [NL*AW-1:0] laneAmts,
  input  shKind_e          kind,
  output logic [VW-1:0]    laneRes
);

  for (genvar i = 0; i < NL; i++) begin : gLane
    shlu_lane #(.W(W)) uLane (
      .laneIn (laneData[i*W +: W]),
      .amt    (laneAmts[i*AW +: AW]),
      .kind   (kind),
      .laneOut(laneRes[i*W +: W])
    );
  end

endmodule

// File: rtl/shlu_ctrl.sv
module shlu_ctrl
  import shlu_pkg::*;
(
  input  logic         opValid,
  input  logic [3:0]   opcode,
  input  logic [3:0]   extraField,
  output ctrlStrobes_t ctl
);

  logic isShiftN, isShiftW, isLogic, isSwap, isNop;

  assign isShiftN = (opcode == OpShiftNarrow);
  assign isShiftW = (opcode == OpShiftWide);
  assign isLogic  = (opcode == OpBitLogic);
  assign isSwap   = isLogic && (extraField == CodeSwap);
  assign isNop    = isLogic && (extraField == CodeNop);

  always_comb begin
    ctl          = '0;
    ctl.capture  = opValid;
    ctl.doShift  = isShiftN || isShiftW;
    ctl.narrow   = isShiftN;
    ctl.useField = extraField[3];
    ctl.negAmt   = extraField[2];
    ctl.kind     = shKind_e'(extraField[1:0]);
    ctl.doLogic  = isLogic;
    ctl.doSwap   = isSwap;
    ctl.wrDst    = opValid && (isShiftN || isShiftW || (isLogic && !isNop));
    ctl.wrSrc    = opValid && isSwap;
  end

endmodule

// File: rtl/shlu_datapath.sv
module shlu_datapath
  import shlu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  ctrlStrobes_t       ctl,
  input  logic [3:0]         logicCode,
  input  logic [FieldW-1:0]  srcField,
  input  logic [VecW-1:0]    srcVal,
  input  logic [VecW-1:0]    dstVal,
  output logic               resValid,
  output logic               dstWe,
  output logic [VecW-1:0]    dstNew,
  output logic               srcWe,
  output logic [VecW-1:0]    srcNew
);

  localparam int NLn = VecW / NarrowW;
  localparam int NLw = VecW / WideW;
  localparam int AWn = $clog2(NarrowW);
  localparam int AWw = $clog2(WideW);

  logic [NLn*AWn-1:0] amtsNarrow;
  logic [NLw*AWw-1:0] amtsWide;
  logic [VecW-1:0]    narrowRes, wideRes, logicRes, nextDst;

  for (genvar i = 0; i < NLn; i++) begin : gAmtN
    logic [AWn-1:0] rawAmt;
    assign rawAmt = ctl.useField ? srcField[AWn-1:0] : srcVal[i*NarrowW +: AWn];
    assign amtsNarrow[i*AWn +: AWn] =
      ctl.negAmt ? (~rawAmt) + {{(AWn-1){1'b0}}, 1'b1} : rawAmt;
  end

  for (genvar i = 0; i < NLw; i++) begin : gAmtW
    logic [AWw-1:0] rawAmt;
    assign rawAmt = ctl.useField ? srcField[AWw-1:0] : srcVal[i*WideW +: AWw];
    assign amtsWide[i*AWw +: AWw] =
      ctl.negAmt ? (~rawAmt) + {{(AWw-1){1'b0}}, 1'b1} : rawAmt;
  end

  shlu_lanes #(.VW(VecW), .W(NarrowW)) uNarrow (
    .laneData(dstVal),
    .laneAmts(amtsNarrow),
    .kind    (ctl.kind),
    .laneRes (narrowRes)
  );

  shlu_lanes #(.VW(VecW), .W(WideW)) uWide (
    .laneData(dstVal),
    .laneAmts(amtsWide),
    .kind    (ctl.kind),
    .laneRes (wideRes)
  );

  // Truth table: bit index is {dst bit, src bit}
  assign logicRes = ({VecW{logicCode[3]}} &  dstVal &  srcVal)
                  | ({VecW{logicCode[2]}} &  dstVal & ~srcVal)
                  | ({VecW{logicCode[1]}} & ~dstVal &  srcVal)
                  | ({VecW{logicCode[0]}} & ~dstVal & ~srcVal);

  always_comb begin
    if (ctl.doShift)      nextDst = ctl.narrow ? narrowRes : wideRes;
    else if (ctl.doLogic) nextDst = logicRes;
    else                  nextDst = dstVal;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resValid <= 1'b0;
      dstWe    <= 1'b0;
      srcWe    <= 1'b0;
      dstNew   <= '0;
      srcNew   <= '0;
    end else if (ctl.capture) begin
      resValid <= 1'b1;
      dstWe    <= ctl.wrDst;
      srcWe    <= ctl.wrSrc;
      dstNew   <= nextDst;
      srcNew   <= ctl.doSwap ? dstVal : srcVal;
    end else begin
      resValid <= 1'b0;
      dstWe    <= 1'b0;
      srcWe    <= 1'b0;
    end
  end

  assert_idle_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !resValid |-> (!dstWe && !srcWe));

  assert_one_cycle_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.capture |=> resValid);

  assert_swap_exchange_R9: assert property (@(posedge clk) disable iff (!rst_n)
    srcWe |-> (dstWe && dstNew == $past(srcVal) && srcNew == $past(dstVal)));

  assert_nop_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.capture && ctl.doLogic && logicCode == CodeNop)
      |=> (!dstWe && dstNew == $past(dstVal)));

  assert_xor_self_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.capture && ctl.doLogic && logicCode == 4'h6 && srcVal == dstVal)
      |=> (dstNew == '0));

endmodule

// File: rtl/simd_shlogic_unit.sv
module simd_shlogic_unit
  import shlu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        opValid,
  input  logic [3:0]  opcode,
  input  logic [3:0]  extraField,
  input  logic [3:0]  srcField,
  input  logic [63:0] srcVal,
  input  logic [63:0] dstVal,
  output logic        resValid,
  output logic        dstWe,
  output logic [63:0] dstNew,
  output logic        srcWe,
  output logic [63:0] srcNew
);

  ctrlStrobes_t ctl;

  shlu_ctrl uCtrl (
    .opValid   (opValid),
    .opcode    (opcode),
    .extraField(extraField),
    .ctl       (ctl)
  );

  shlu_datapath uDp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl),
    .logicCode(extraField),
    .srcField (srcField),
    .srcVal   (srcVal),
    .dstVal   (dstVal),
    .resValid (resValid),
    .dstWe    (dstWe),
    .dstNew   (dstNew),
    .srcWe    (srcWe),
    .srcNew   (srcNew)
  );

endmodule

// File: tb/tb_simd_shlogic_unit.sv
module tb_simd_shlogic_unit;

  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] OPA = 64'hFFFF_0000_FFFF_0000;
  localparam logic [63:0] OPB = 64'hFFFF_FFFF_0000_0000;

  typedef struct packed {
    logic [7:0]  req;
    logic [3:0]  op;
    logic [3:0]  ext;
    logic [3:0]  fld;
    logic [63:0] src;
    logic [63:0] dst;
    logic [63:0] expDst;
    logic [63:0] expSrc;
    logic        wd;
    logic        ws;
  } vec_t;

  localparam int NVEC = 29;
  localparam vec_t VECS [NVEC] = '{
    '{8'd6,  4'hB, 4'h8, 4'h4, 64'h0, 64'h0001_0002_8000_00FF, 64'h0010_0020_0000_0FF0, 64'h0, 1'b1, 1'b0}, // R6 R3
    '{8'd4,  4'hB, 4'hA, 4'h4, 64'h0, 64'h8000_7FF0_FFFF_1234, 64'hF800_07FF_FFFF_0123, 64'h0, 1'b1, 1'b0}, // R4 arith
    '{8'd3,  4'hA, 4'h9, 4'h1, 64'h0, 64'h80FF_0102_0304_F00F, 64'h407F_0001_0102_7807, 64'h0, 1'b1, 1'b0}, // R3 narrow
    '{8'd5,  4'hA, 4'h3, 4'h0, 64'h0001_0203_0405_0607, 64'h8181_8181_8181_8181,
                                64'h8103_060C_1830_60C0, 64'h0001_0203_0405_0607, 1'b1, 1'b0},             // R5 rotl
    '{8'd4,  4'hB, 4'hF, 4'h4, 64'h0, 64'h1234_ABCD_0001_F000, 64'h4123_DABC_1000_0F00, 64'h0, 1'b1, 1'b0}, // R4 rotr
    '{8'd7,  4'hB, 4'hC, 4'h3, 64'h0, 64'h0001_0003_FFFF_0008, 64'h2000_6000_E000_0000, 64'h0, 1'b1, 1'b0}, // R7
    '{8'd7,  4'hB, 4'h5, 4'h0, 64'h0000_0001_000F_0008, 64'h8000_8000_8000_8000,
                                64'h8000_0001_4000_0080, 64'h0000_0001_000F_0008, 1'b1, 1'b0},             // R7 per lane
    '{8'd7,  4'hA, 4'hE, 4'h9, 64'h0, 64'h807F_0180_FF01_7FC0, 64'hFF00_00FF_FF00_00FF, 64'h0, 1'b1, 1'b0}, // R7 R6
    '{8'd5,  4'hA, 4'h0, 4'h7, 64'h0A0A_0A0A_0A0A_0A0A, 64'h0101_0101_0101_0101,
                                64'h0404_0404_0404_0404, 64'h0A0A_0A0A_0A0A_0A0A, 1'b1, 1'b0},             // R5 mask
    '{8'd6,  4'hA, 4'h8, 4'h8, 64'h0, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 64'h0, 1'b1, 1'b0}, // R6 mod 8
    '{8'd5,  4'hB, 4'h3, 4'h0, 64'h0013_0000_0004_0011, 64'h8001_8001_8001_8001,
                                64'h000C_8001_0018_0003, 64'h0013_0000_0004_0011, 1'b1, 1'b0},             // R5 wide
    '{8'd8,  4'hC, 4'h8, 4'h0, OPA, OPB, 64'hFFFF_0000_0000_0000, OPA, 1'b1, 1'b0}, // R8 and
    '{8'd8,  4'hC, 4'hE, 4'h0, OPA, OPB, 64'hFFFF_FFFF_FFFF_0000, OPA, 1'b1, 1'b0}, // R8 or
    '{8'd8,  4'hC, 4'h6, 4'h0, OPA, OPB, 64'h0000_FFFF_FFFF_0000, OPA, 1'b1, 1'b0}, // R8 xor
    '{8'd8,  4'hC, 4'h7, 4'h0, OPA, OPB, 64'h0000_FFFF_FFFF_FFFF, OPA, 1'b1, 1'b0}, // R8 nand
    '{8'd8,  4'hC, 4'h1, 4'h0, OPA, OPB, 64'h0000_0000_0000_FFFF, OPA, 1'b1, 1'b0}, // R8 nor
    '{8'd8,  4'hC, 4'h9, 4'h0, OPA, OPB, 64'hFFFF_0000_0000_FFFF, OPA, 1'b1, 1'b0}, // R8 xnor
    '{8'd8,  4'hC, 4'h2, 4'h0, OPA, OPB, 64'h0000_0000_FFFF_0000, OPA, 1'b1, 1'b0}, // R8
    '{8'd8,  4'hC, 4'h4, 4'h0, OPA, OPB, 64'h0000_FFFF_0000_0000, OPA, 1'b1, 1'b0}, // R8
    '{8'd8,  4'hC, 4'hB, 4'h0, OPA, OPB, 64'hFFFF_0000_FFFF_FFFF, OPA, 1'b1, 1'b0}, // R8
    '{8'd8,  4'hC, 4'hD, 4'h0, OPA, OPB, 64'hFFFF_FFFF_0000_FFFF, OPA, 1'b1, 1'b0}, // R8
    '{8'd8,  4'hC, 4'h5, 4'h0, OPA, OPB, 64'h0000_FFFF_0000_FFFF, OPA, 1'b1, 1'b0}, // R8 not src
    '{8'd8,  4'hC, 4'h3, 4'h0, OPA, OPB, 64'h0000_0000_FFFF_FFFF, OPA, 1'b1, 1'b0}, // R8 not dst
    '{8'd8,  4'hC, 4'h0, 4'h0, OPA, OPB, 64'h0, OPA, 1'b1, 1'b0},                   // R8 zero
    '{8'd8,  4'hC, 4'hF, 4'h0, OPA, OPB, 64'hFFFF_FFFF_FFFF_FFFF, OPA, 1'b1, 1'b0}, // R8 ones
    '{8'd11, 4'hC, 4'h6, 4'h0, 64'hDEAD_BEEF_0123_4567, 64'hDEAD_BEEF_0123_4567,
                                64'h0, 64'hDEAD_BEEF_0123_4567, 1'b1, 1'b0},       // R11
    '{8'd9,  4'hC, 4'hA, 4'h0, OPA, OPB, OPA, OPB, 1'b1, 1'b1},                     // R9 swap
    '{8'd10, 4'hC, 4'hC, 4'h0, OPA, OPB, OPB, OPA, 1'b0, 1'b0},                     // R10 nop
    '{8'd12, 4'h9, 4'h0, 4'h0, OPA, OPB, OPB, OPA, 1'b0, 1'b0}                      // R12 other opcode
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        opValid = 1'b0;
  logic [3:0]  opcode = '0, extraField = '0, srcField = '0;
  logic [63:0] srcVal = '0, dstVal = '0;
  logic        resValid, dstWe, srcWe;
  logic [63:0] dstNew, srcNew;

  int nApplied = 0;
  int nMiss = 0;
  bit finished = 1'b0;

  simd_shlogic_unit dut (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opcode(opcode),
    .extraField(extraField), .srcField(srcField), .srcVal(srcVal), .dstVal(dstVal),
    .resValid(resValid), .dstWe(dstWe), .dstNew(dstNew), .srcWe(srcWe), .srcNew(srcNew)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    nApplied++;
    if (act !== exp) begin
      nMiss++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] op, input logic [3:0] ext, input logic [3:0] fld,
                       input logic [63:0] s, input logic [63:0] d);
    opValid = 1'b1; opcode = op; extraField = ext; srcField = fld; srcVal = s; dstVal = d;
  endtask

  task automatic finishRun;
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nApplied, nMiss);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nApplied++;
    nMiss++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "resValid", {63'd0, resValid}, 64'd0);
    chk("R1", "dstWe", {63'd0, dstWe}, 64'd0);
    chk("R1", "srcWe", {63'd0, srcWe}, 64'd0);
    chk("R1", "dstNew", dstNew, 64'd0);
    chk("R1", "srcNew", srcNew, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "resValid after release", {63'd0, resValid}, 64'd0);

    // Vector table, one operation each, idle cycle between
    for (int i = 0; i < NVEC; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      @(negedge clk);
      drive(VECS[i].op, VECS[i].ext, VECS[i].fld, VECS[i].src, VECS[i].dst);
      @(negedge clk);
      opValid = 1'b0;
      chk(tag, "resValid", {63'd0, resValid}, 64'd1);
      chk(tag, "dstNew", dstNew, VECS[i].expDst);
      chk(tag, "srcNew", srcNew, VECS[i].expSrc);
      chk(tag, "dstWe", {63'd0, dstWe}, {63'd0, VECS[i].wd});
      chk(tag, "srcWe", {63'd0, srcWe}, {63'd0, VECS[i].ws});
    end

    // R2: idle cycle gives no result and no write
    @(negedge clk);
    chk("R2", "idle resValid", {63'd0, resValid}, 64'd0);
    chk("R2", "idle dstWe", {63'd0, dstWe}, 64'd0);

    // R2 R9 R12: swap followed back-to-back by a plain shift
    @(negedge clk);
    drive(4'hC, 4'hA, 4'h0, 64'h0000_0000_1111_2222, 64'h3333_4444_0000_0000);
    @(negedge clk);
    chk("R9", "swap dstNew", dstNew, 64'h0000_0000_1111_2222);
    chk("R9", "swap srcNew", srcNew, 64'h3333_4444_0000_0000);
    chk("R9", "swap srcWe", {63'd0, srcWe}, 64'd1);
    chk("R9", "swap dstWe", {63'd0, dstWe}, 64'd1);
    drive(4'hB, 4'h8, 4'h1, 64'h5555_0000_0000_0000, 64'h0001_0001_0001_0001);
    @(negedge clk);
    drive(4'hC, 4'hE, 4'h0, 64'h00F0, 64'h000F);
    chk("R2", "back-to-back resValid", {63'd0, resValid}, 64'd1);
    chk("R12", "shift after swap srcWe", {63'd0, srcWe}, 64'd0);
    chk("R12", "shift after swap srcNew", srcNew, 64'h5555_0000_0000_0000);
    chk("R3", "wide shift", dstNew, 64'h0002_0002_0002_0002);
    @(negedge clk);
    opValid = 1'b0;
    chk("R2", "third back-to-back", dstNew, 64'h00FF);

    // R1: reset in the middle of a run
    @(negedge clk);
    drive(4'hC, 4'hF, 4'h0, 64'h0, 64'h0);
    @(negedge clk);
    opValid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "mid reset dstNew", dstNew, 64'd0);
    chk("R1", "mid reset resValid", {63'd0, resValid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    finishRun();
  end

endmodule